// File: doc/BRIEF.md
# Five-Source Priority Interrupt Controller

This block sits next to a small CPU core and decides which of five request lines interrupts the core. One source is a non-maskable trap that always gets through. The other four are maskable: three fixed-vector restart lines and one general request whose vector comes from outside. The block drives a single request line toward the core, together with an 8-bit restart address for the winning source. For the general request it raises a flag instead, because that source is vectored externally.

The core controls the block with three kinds of command. Enable and disable pulses set and clear a global enable bit, which gates only the maskable sources. A mask write loads per-line block bits for the three restart lines and can also discard a pending edge on the highest restart line. When the core takes an interrupt, it pulses an acknowledge. The acknowledge retires the serviced edge-type request and clears the global enable, so any further maskable interrupt needs a new enable command.

Top module: `prio_intc`

## Requirements
- R1: After a synchronous reset, the global enable is 0, all three restart mask bits are 1 (blocked), and both edge latches are empty. `irq_o` is 0 even if `gen_i` is high.
- R2: A rising edge on `trap_i` is latched. From the next cycle on, `irq_o`=1 and `vec_o`=0x24, whatever the enable and mask state. The request stays until an acknowledge clears it.
- R3: The four maskable sources are delivered only while the global enable is 1. The global enable behaves as follows:
  - An `en_cmd` pulse sets it, effective in the next cycle.
  - A `dis_cmd` pulse clears it.
  - If both pulse in the same cycle, the disable wins.
- R4: Priority is trap > `r75` > `r65` > `r55` > `gen`. The vectors are:
  - trap: 0x24
  - `r75`: 0x3C
  - `r65`: 0x34
  - `r55`: 0x2C
  - `gen`: `vec_o`=0x00 with `ext_vec_o`=1
- R5: A cycle with `mask_wr`=1 loads `mask_data`. Bit 2 blocks `r75`, bit 1 blocks `r65` and bit 0 blocks `r55` (1 = blocked). The new mask is effective in the next cycle. `gen_i` has no mask bit.
- R6: A rising edge on `r75_i` is latched and held after the input falls, even while the line is masked or disabled. The latch is cleared by an acknowledge while `r75` is the winner, or by a mask write with `clr75`=1. A new edge in the same cycle as a clear wins.
- R7: An acknowledge clears the global enable, and it does so ahead of an enable in the same cycle. It also clears the latch of the winning source if that source is the trap or `r75`. The level sources `r65`, `r55` and `gen` are not cleared by an acknowledge.
- R8: `r65_i`, `r55_i` and `gen_i` are level-sensitive and reach `irq_o` in the same cycle. While `irq_o`=0, `vec_o`=0x00 and `ext_vec_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_i | input | 1 | Non-maskable request, edge-latched |
| r75_i | input | 1 | Highest restart request, edge-latched |
| r65_i | input | 1 | Middle restart request, level |
| r55_i | input | 1 | Lowest restart request, level |
| gen_i | input | 1 | General request, level, externally vectored |
| en_cmd | input | 1 | Global enable set pulse |
| dis_cmd | input | 1 | Global enable clear pulse |
| mask_wr | input | 1 | Mask write strobe |
| mask_data | input | 3 | Mask bits {r75, r65, r55}, 1 = blocked |
| clr75 | input | 1 | With `mask_wr`, discard pending `r75` edge |
| ack_i | input | 1 | Core acknowledge of current request |
| irq_o | output | 1 | Interrupt request to core |
| vec_o | output | 8 | Restart address of winning source |
| ext_vec_o | output | 1 | Winner is the externally vectored request |

## Verification
The bench sweeps every combination of global enable, mask word and level-line inputs. A design with the priority order swapped, or with a mask bit wired to the wrong line, would show a wrong vector in that sweep. Edge tests hold `r75` pending through masking and disabling, then release it. A design that sampled the level of `r75` instead of latching its edge would lose the request, and one that ignored `clr75` would still deliver 0x3C after the discard. Trap tests run with the enable off and the masks set. A trap that was wrongly gated would stay silent. If an acknowledge failed to clear the enable, a level line would reappear right after service. Same-cycle enable/disable and ack/enable conflicts are also driven, to catch a wrong command priority.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

    localparam int NSRC   = 5;
    localparam int VEC_W  = 8;
    localparam int NMASK  = 3;

    typedef enum logic [2:0] {
        SRC_TRAP = 3'd0,
        SRC_R75  = 3'd1,
        SRC_R65  = 3'd2,
        SRC_R55  = 3'd3,
        SRC_GEN  = 3'd4
    } src_e;

    typedef struct packed {
        logic             irq;
        logic             ext;
        logic [VEC_W-1:0] vec;
    } intc_out_t;

    // Restart address for each fixed-vector source
    function automatic logic [VEC_W-1:0] vec_of(input int idx);
        case (idx)
            SRC_TRAP: vec_of = 8'h24;
            SRC_R75:  vec_of = 8'h3C;
            SRC_R65:  vec_of = 8'h34;
            SRC_R55:  vec_of = 8'h2C;
            default:  vec_of = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/intc_edge_latch.sv
module intc_edge_latch (
    input  logic clk,
    input  logic rst,
    input  logic req_in,
    input  logic clr,
    output logic pend
);
    logic prev_q;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= req_in;
            // a fresh edge beats a clear in the same cycle
            pend_q <= (req_in & ~prev_q) | (pend_q & ~clr);
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/intc_ctrl_regs.sv
module intc_ctrl_regs
    import prio_intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en_cmd,
    input  logic             dis_cmd,
    input  logic             taken,
    input  logic             mask_wr,
    input  logic [NMASK-1:0] mask_data,
    output logic             ie,
    output logic [NMASK-1:0] mask
);
    logic             ie_q;
    logic [NMASK-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q   <= 1'b0;
            mask_q <= '1;
        end else begin
            if (taken || dis_cmd) ie_q <= 1'b0;
            else if (en_cmd)      ie_q <= 1'b1;
            if (mask_wr)          mask_q <= mask_data;
        end
    end

    assign ie   = ie_q;
    assign mask = mask_q;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import prio_intc_pkg::*;
(
    input  logic [NSRC-1:0] elig,
    output logic [NSRC-1:0] grant,
    output intc_out_t       res
);
    always_comb begin
        grant   = '0;
        res     = '0;
        // index 0 is the highest priority
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                grant     = '0;
                grant[i]  = 1'b1;
                res.irq   = 1'b1;
                res.ext   = (i == int'(SRC_GEN));
                res.vec   = vec_of(i);
            end
        end
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             trap_i,
    input  logic             r75_i,
    input  logic             r65_i,
    input  logic             r55_i,
    input  logic             gen_i,
    input  logic             en_cmd,
    input  logic             dis_cmd,
    input  logic             mask_wr,
    input  logic [NMASK-1:0] mask_data,
    input  logic             clr75,
    input  logic             ack_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             ext_vec_o
);
    localparam int NEDGE = 2;

    logic             ie_q;
    logic [NMASK-1:0] mask_q;
    logic [NSRC-1:0]  elig;
    logic [NSRC-1:0]  grant;
    intc_out_t        res;
    logic [NEDGE-1:0] edge_in;
    logic [NEDGE-1:0] edge_clr;
    logic [NEDGE-1:0] edge_pend;

    assign edge_in  = {r75_i, trap_i};
    assign edge_clr = {(ack_i & grant[SRC_R75]) | (mask_wr & clr75),
                       ack_i & grant[SRC_TRAP]};

    for (genvar g = 0; g < NEDGE; g++) begin : g_edge
        intc_edge_latch u_lat (
            .clk    (clk),
            .rst    (rst),
            .req_in (edge_in[g]),
            .clr    (edge_clr[g]),
            .pend   (edge_pend[g])
        );
    end

    intc_ctrl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .en_cmd    (en_cmd),
        .dis_cmd   (dis_cmd),
        .taken     (ack_i),
        .mask_wr   (mask_wr),
        .mask_data (mask_data),
        .ie        (ie_q),
        .mask      (mask_q)
    );

    always_comb begin
        elig           = '0;
        elig[SRC_TRAP] = edge_pend[0];
        elig[SRC_R75]  = ie_q & ~mask_q[2] & edge_pend[1];
        elig[SRC_R65]  = ie_q & ~mask_q[1] & r65_i;
        elig[SRC_R55]  = ie_q & ~mask_q[0] & r55_i;
        elig[SRC_GEN]  = ie_q & gen_i;
    end

    intc_arbiter u_arb (
        .elig  (elig),
        .grant (grant),
        .res   (res)
    );

    assign irq_o     = res.irq;
    assign vec_o     = res.vec;
    assign ext_vec_o = res.ext;
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk (
    input logic       clk,
    input logic       rst,
    input logic       trap_i,
    input logic       r55_i,
    input logic       ack_i,
    input logic       irq_o,
    input logic [7:0] vec_o,
    input logic       ext_vec_o,
    input logic       ie_q,
    input logic [2:0] mask_q,
    input logic [4:0] grant
);
    a_r2_trap_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(trap_i) |=> (irq_o && vec_o == 8'h24));

    a_r3_gated: assert property (@(posedge clk) disable iff (rst)
        (irq_o && vec_o != 8'h24) |-> ie_q);

    a_r4_one_winner: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    a_r5_mask_r55: assert property (@(posedge clk) disable iff (rst)
        ext_vec_o |-> !(r55_i && !mask_q[0]));

    a_r7_ack_ie: assert property (@(posedge clk) disable iff (rst)
        ack_i |=> !ie_q);

    a_r8_idle: assert property (@(posedge clk) disable iff (rst)
        !irq_o |-> (vec_o == 8'h00 && !ext_vec_o));
endmodule

bind prio_intc prio_intc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .trap_i    (trap_i),
    .r55_i     (r55_i),
    .ack_i     (ack_i),
    .irq_o     (irq_o),
    .vec_o     (vec_o),
    .ext_vec_o (ext_vec_o),
    .ie_q      (ie_q),
    .mask_q    (mask_q),
    .grant     (grant)
);

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
    logic       clk = 1'b0;
    logic       rst;
    logic       trap_i, r75_i, r65_i, r55_i, gen_i;
    logic       en_cmd, dis_cmd, mask_wr, clr75, ack_i;
    logic [2:0] mask_data;
    logic       irq_o, ext_vec_o;
    logic [7:0] vec_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    prio_intc u0 (
        .clk(clk), .rst(rst), .trap_i(trap_i), .r75_i(r75_i),
        .r65_i(r65_i), .r55_i(r55_i), .gen_i(gen_i),
        .en_cmd(en_cmd), .dis_cmd(dis_cmd), .mask_wr(mask_wr),
        .mask_data(mask_data), .clr75(clr75), .ack_i(ack_i),
        .irq_o(irq_o), .vec_o(vec_o), .ext_vec_o(ext_vec_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(string req, logic ei, logic [7:0] ev, logic ex);
        #1;
        n_chk++;
        if (irq_o !== ei || vec_o !== ev || ext_vec_o !== ex) begin
            n_bad++;
            $display("FAIL %s: got irq=%0b vec=%02h ext=%0b, want irq=%0b vec=%02h ext=%0b",
                     req, irq_o, vec_o, ext_vec_o, ei, ev, ex);
        end
    endtask

    task automatic cmd_clear();
        en_cmd = 0; dis_cmd = 0; mask_wr = 0; clr75 = 0; ack_i = 0;
    endtask

    task automatic set_cfg(logic ie, logic [2:0] m);
        mask_wr = 1; mask_data = m; en_cmd = ie; dis_cmd = !ie;
        tick();
        cmd_clear();
    endtask

    task automatic ack();
        ack_i = 1;
        tick();
        cmd_clear();
    endtask

    initial begin
        #150000;
        n_bad++;
        $display("FAIL watchdog: got timeout, want finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1; cmd_clear(); mask_data = 0;
        trap_i = 0; r75_i = 0; r65_i = 0; r55_i = 0; gen_i = 0;
        tick(); tick();
        rst = 0;
        gen_i = 1;
        expect_out("R1 reset blocks gen", 0, 8'h00, 0);
        en_cmd = 1; tick(); cmd_clear();
        expect_out("R1 ie starts 0, R3 en sets", 1, 8'h00, 1);
        gen_i = 0;

        // R4 R5 R8 sweep of levels x enable x mask
        for (int ie = 0; ie < 2; ie++) begin
            for (int m = 0; m < 8; m++) begin
                set_cfg(ie[0], m[2:0]);
                for (int lv = 0; lv < 8; lv++) begin
                    logic       ei, ex;
                    logic [7:0] ev;
                    r65_i = lv[2]; r55_i = lv[1]; gen_i = lv[0];
                    ei = 0; ex = 0; ev = 8'h00;
                    if (ie == 1) begin
                        if (lv[2] && !m[1])      begin ei = 1; ev = 8'h34; end
                        else if (lv[1] && !m[0]) begin ei = 1; ev = 8'h2C; end
                        else if (lv[0])          begin ei = 1; ex = 1; end
                    end
                    expect_out("R4 R5 R8 sweep", ei, ev, ex);
                end
                r65_i = 0; r55_i = 0; gen_i = 0;
            end
        end

        // R2 trap with enable off and all masked
        set_cfg(0, 3'b111);
        trap_i = 1; tick(); trap_i = 0;
        expect_out("R2 trap non-maskable", 1, 8'h24, 0);
        tick();
        expect_out("R2 trap held", 1, 8'h24, 0);
        ack();
        expect_out("R7 ack clears trap", 0, 8'h00, 0);

        // R6 R4 r75 edge latched over r65
        set_cfg(1, 3'b000);
        r75_i = 1; tick(); r75_i = 0;
        r65_i = 1;
        expect_out("R6 R4 r75 beats r65", 1, 8'h3C, 0);
        ack();
        expect_out("R7 ack clears ie", 0, 8'h00, 0);
        en_cmd = 1; tick(); cmd_clear();
        expect_out("R7 level r65 kept", 1, 8'h34, 0);
        r65_i = 0;

        // R6 masked edge retained
        set_cfg(1, 3'b100);
        r75_i = 1; tick(); r75_i = 0;
        expect_out("R6 masked r75 silent", 0, 8'h00, 0);
        set_cfg(1, 3'b000);
        expect_out("R6 r75 kept while masked", 1, 8'h3C, 0);
        ack();

        // R6 clr75 discards pending edge
        set_cfg(0, 3'b000);
        r75_i = 1; tick(); r75_i = 0;
        mask_wr = 1; mask_data = 3'b000; clr75 = 1; tick(); cmd_clear();
        en_cmd = 1; tick(); cmd_clear();
        expect_out("R6 clr75 discards", 0, 8'h00, 0);

        // R3 disable beats enable
        gen_i = 1;
        dis_cmd = 1; tick(); cmd_clear();
        en_cmd = 1; dis_cmd = 1; tick(); cmd_clear();
        expect_out("R3 dis wins", 0, 8'h00, 0);
        // R7 ack beats enable
        en_cmd = 1; tick(); cmd_clear();
        expect_out("R3 en after", 1, 8'h00, 1);
        en_cmd = 1; ack_i = 1; tick(); cmd_clear();
        expect_out("R7 ack beats en", 0, 8'h00, 0);
        gen_i = 0;

        // R2 R6 trap and r75 pending, trap served first
        set_cfg(1, 3'b000);
        trap_i = 1; r75_i = 1; tick(); trap_i = 0; r75_i = 0;
        expect_out("R2 trap over r75", 1, 8'h24, 0);
        ack();
        expect_out("R6 r75 waits for enable", 0, 8'h00, 0);
        en_cmd = 1; tick(); cmd_clear();
        expect_out("R6 r75 after trap", 1, 8'h3C, 0);
        ack();
        en_cmd = 1; tick(); cmd_clear();
        expect_out("R7 r75 cleared by ack", 0, 8'h00, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule